// File: doc/BRIEF.md
# Two-Rate Token Bucket Egress Shaper

This block limits the egress rate of one transmit channel using two token buckets: a commit bucket and a peak bucket. A bucket is refilled on a programmable tick by a fixed-point token increment, and it holds at most a power-of-two number of tokens. A transmit request must find enough tokens in every enabled bucket. When it does, the block grants it in the same cycle and takes the cost from each enabled bucket. A request costs its byte length, or one token when that bucket counts packets.

The tick for each bucket comes from a shared fast-tick counter, or, when the bucket selects the slow tick, from every Nth fast tick, where N is the slow ratio. Each bucket has its own configuration: enable, packet mode, tick select, a rate word and a size shift. A disabled bucket never blocks traffic and is never debited. The level of each bucket is output so that the fill state can be observed.

Top module: `dual_bucket_shaper`

## Requirements
- R1: While `rst_n` is low, each bucket level is loaded with its full capacity, and the tick counters are cleared.
- R2: Bucket capacity is 2^s tokens, where s is the size shift clamped to the range 12..17. A shift below 12 gives 4096 and a shift above 17 gives 131072.
- R3: With tick select clear, a bucket refills once every `fast_tick` cycles. The first refill lands `fast_tick` cycles after the counter leaves zero. A `fast_tick` of zero stops all refill.
- R4: With tick select set, a bucket refills once every `fast_tick` × `slow_ratio` cycles. A ratio of zero stops its refill.
- R5: The rate word holds whole tokens per tick in bits 23:6 and a fraction in 1/64 units in bits 5:0. The fraction accumulates across ticks and adds one token whenever it carries.
- R6: Refill never raises a level above the bucket capacity.
- R7: `permit` is high only when `req_valid` is high and every enabled bucket holds at least its cost. The cost is `req_len` bytes, or 1 when that bucket's packet-mode bit is set.
- R8: On a permitted request, each enabled bucket is reduced by its cost at the next clock edge. A refused request leaves every level unchanged.
- R9: A disabled bucket neither refuses a request nor is debited.
- R10: When a permit and a refill of the same bucket fall in the same cycle, the new level is min(level − cost + increment, capacity).
- R11: `permit` is combinational from the request and the current levels, and it is valid in the cycle the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 16 | Fast tick period in cycles; 0 halts ticks |
| slow_ratio | input | 14 | Fast ticks per slow tick; 0 halts slow ticks |
| c_en | input | 1 | Commit bucket enable |
| c_pkt | input | 1 | Commit bucket counts packets |
| c_slow | input | 1 | Commit bucket uses the slow tick |
| c_rate | input | 24 | Commit rate, 18.6 fixed point |
| c_shift | input | 5 | Commit size shift |
| p_en | input | 1 | Peak bucket enable |
| p_pkt | input | 1 | Peak bucket counts packets |
| p_slow | input | 1 | Peak bucket uses the slow tick |
| p_rate | input | 24 | Peak rate, 18.6 fixed point |
| p_shift | input | 5 | Peak size shift |
| req_valid | input | 1 | Transmit request present |
| req_len | input | 16 | Request length in bytes |
| permit | output | 1 | Request conforms and is granted |
| c_level | output | 18 | Commit bucket token level |
| p_level | output | 18 | Peak bucket token level |

## Verification
A refill and a debit can land on the same bucket in the same cycle. The bench provokes this case on purpose. It first counts cycles from a known tick phase with a 10-cycle fast tick. It then presents a 500-byte request in exactly the cycle that carries the tick, with the commit bucket full and a 100-token increment. The expected commit level is 3696, which is only reached if the debit is taken first and the result is then clamped to capacity. Clamping first and then debiting would give 3596. The same edge also checks the peak bucket, which has no refill, to confirm that it was debited by the full 500.

// File: rtl/shaper_pkg.sv
// Shared widths and the per-bucket configuration record of the egress shaper.
package shaper_pkg;
    localparam int FAST_W    = 16;
    localparam int RATIO_W   = 14;
    localparam int FRAC_W    = 6;
    localparam int WHOLE_W   = 18;
    localparam int RATE_W    = WHOLE_W + FRAC_W;
    localparam int SHIFT_W   = 5;
    localparam int SHIFT_MIN = 12;
    localparam int SHIFT_MAX = 17;
    localparam int LVL_W     = SHIFT_MAX + 1;
    localparam int LEN_W     = 16;
    localparam int NBUCKET   = 2;

    typedef struct packed {
        logic               en;
        logic               pkt;
        logic               slow;
        logic [RATE_W-1:0]  rate;
        logic [SHIFT_W-1:0] shift;
    } bucket_cfg_t;
endpackage

// File: rtl/shaper_tick_gen.sv
// Tick generator: emits a one-cycle fast pulse every fast_tick cycles and a
// slow pulse on every slow_ratio-th fast pulse. Assumes the period inputs are
// quasi-static; a zero period halts the corresponding pulse.
module shaper_tick_gen #(
    parameter int FAST_W  = 16,
    parameter int RATIO_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FAST_W-1:0]  fast_tick,
    input  logic [RATIO_W-1:0] slow_ratio,
    output logic               fast_pulse,
    output logic               slow_pulse
);
    logic [FAST_W-1:0]  cyc_cnt;
    logic [RATIO_W-1:0] fast_cnt;

    // Decode the pulses from the counters; >= keeps a lowered period safe.
    always_comb begin
        fast_pulse = (fast_tick != '0) && (cyc_cnt >= fast_tick - 1'b1);
        slow_pulse = fast_pulse && (slow_ratio != '0) &&
                     (fast_cnt >= slow_ratio - 1'b1);
    end

    // Cycle counter: wraps on each fast pulse, held at zero when halted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_cnt <= '0;
        else if (fast_tick == '0 || fast_pulse)
            cyc_cnt <= '0;
        else
            cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Fast pulse counter: wraps on each slow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fast_cnt <= '0;
        else if (fast_pulse)
            fast_cnt <= (slow_pulse || slow_ratio == '0) ? '0 : fast_cnt + 1'b1;
    end

    // R3
    tick_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_tick == '0) |-> !fast_pulse);
    // R4
    slow_on_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_pulse |-> fast_pulse);
endmodule

// File: rtl/shaper_bucket.sv
// One token bucket. It refills on its selected tick with an 18.6 fixed-point
// increment, saturates at 2^shift (shift clamped to SHIFT_MIN..SHIFT_MAX),
// and reports whether it covers the request cost. Assumes the debit input is
// only raised when every bucket has agreed. Debit is applied before refill,
// and the clamp is applied last.
module shaper_bucket
    import shaper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bucket_cfg_t       cfg,
    input  logic              fast_pulse,
    input  logic              slow_pulse,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              debit,
    output logic              ok,
    output logic [LVL_W-1:0]  level
);
    localparam int SUM_W = LVL_W + 2;

    logic [SHIFT_W-1:0] shift_eff;
    logic [LVL_W-1:0]   cap;
    logic [LVL_W-1:0]   need;
    logic               tick;
    logic               take;
    logic [FRAC_W:0]    frac_sum;
    logic [SUM_W-1:0]   add;
    logic [SUM_W-1:0]   after;
    logic [LVL_W-1:0]   nxt;
    logic [FRAC_W-1:0]  frac;

    // Clamp the size shift and form the capacity.
    always_comb begin
        if (cfg.shift < SHIFT_W'(SHIFT_MIN))
            shift_eff = SHIFT_W'(SHIFT_MIN);
        else if (cfg.shift > SHIFT_W'(SHIFT_MAX))
            shift_eff = SHIFT_W'(SHIFT_MAX);
        else
            shift_eff = cfg.shift;
        cap = LVL_W'(1) << shift_eff;
    end

    // Request cost, conformance and debit qualification.
    always_comb begin
        need = cfg.pkt ? LVL_W'(1) : LVL_W'(req_len);
        ok   = !cfg.en || (level >= need);
        take = cfg.en && debit;
        tick = cfg.slow ? slow_pulse : fast_pulse;
    end

    // Refill amount with fraction carry, then debit, refill and clamp.
    always_comb begin
        frac_sum = {1'b0, frac} + {1'b0, cfg.rate[FRAC_W-1:0]};
        add      = tick ? SUM_W'(cfg.rate[RATE_W-1:FRAC_W]) + SUM_W'(frac_sum[FRAC_W])
                        : '0;
        after    = SUM_W'(take ? level - need : level) + add;
        nxt      = (after > SUM_W'(cap)) ? cap : after[LVL_W-1:0];
    end

    // Token level register; starts full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= cap;
        else
            level <= nxt;
    end

    // Fraction accumulator; advances on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frac <= '0;
        else if (tick)
            frac <= frac_sum[FRAC_W-1:0];
    end

    // R6
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= $past(cap));
    // R8
    debit_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !tick) |=> level == $past(level) - $past(need));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !tick) |=> level <= $past(level));
    // R9
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> ok);
endmodule

// File: rtl/dual_bucket_shaper.sv
// Top of the two-rate egress shaper. It holds one shared tick generator and
// one commit and one peak bucket built from the same generate loop. A request
// is granted combinationally when all enabled buckets conform, and the grant
// drives the debit of both buckets.
module dual_bucket_shaper
    import shaper_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FAST_W-1:0]  fast_tick,
    input  logic [RATIO_W-1:0] slow_ratio,
    input  logic               c_en,
    input  logic               c_pkt,
    input  logic               c_slow,
    input  logic [RATE_W-1:0]  c_rate,
    input  logic [SHIFT_W-1:0] c_shift,
    input  logic               p_en,
    input  logic               p_pkt,
    input  logic               p_slow,
    input  logic [RATE_W-1:0]  p_rate,
    input  logic [SHIFT_W-1:0] p_shift,
    input  logic               req_valid,
    input  logic [LEN_W-1:0]   req_len,
    output logic               permit,
    output logic [LVL_W-1:0]   c_level,
    output logic [LVL_W-1:0]   p_level
);
    logic                      fast_pulse;
    logic                      slow_pulse;
    bucket_cfg_t               cfg   [NBUCKET];
    logic [NBUCKET-1:0]        ok;
    logic [LVL_W-1:0]          lvl   [NBUCKET];

    // Gather the flat configuration ports into per-bucket records.
    always_comb begin
        cfg[0] = '{en: c_en, pkt: c_pkt, slow: c_slow, rate: c_rate, shift: c_shift};
        cfg[1] = '{en: p_en, pkt: p_pkt, slow: p_slow, rate: p_rate, shift: p_shift};
    end

    shaper_tick_gen #(.FAST_W(FAST_W), .RATIO_W(RATIO_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_tick  (fast_tick),
        .slow_ratio (slow_ratio),
        .fast_pulse (fast_pulse),
        .slow_pulse (slow_pulse)
    );

    for (genvar b = 0; b < NBUCKET; b++) begin : g_bucket
        shaper_bucket u_bkt (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg        (cfg[b]),
            .fast_pulse (fast_pulse),
            .slow_pulse (slow_pulse),
            .req_len    (req_len),
            .debit      (permit),
            .ok         (ok[b]),
            .level      (lvl[b])
        );
    end

    // Grant when every bucket agrees; expose the levels.
    always_comb begin
        permit  = req_valid && (&ok);
        c_level = lvl[0];
        p_level = lvl[1];
    end

    // R11
    permit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> req_valid);
    // R7
    commit_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_en && !c_pkt && (c_level < LVL_W'(req_len))) |-> !permit);
    // R7
    peak_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && p_en && p_pkt && (p_level == '0)) |-> !permit);
endmodule

// File: tb/tb_dual_bucket_shaper.sv
module tb_dual_bucket_shaper;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] fast_tick;
    logic [13:0] slow_ratio;
    logic        c_en, c_pkt, c_slow, p_en, p_pkt, p_slow;
    logic [23:0] c_rate, p_rate;
    logic [4:0]  c_shift, p_shift;
    logic        req_valid;
    logic [15:0] req_len;
    logic        permit;
    logic [17:0] c_level, p_level;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dual_bucket_shaper dut (.*);

    typedef struct packed {
        logic        en_c;
        logic        pk_c;
        logic        pk_p;
        logic [15:0] len;
        logic        perm;
        logic [17:0] lc;
        logic [17:0] lp;
    } vec_t;

    // Ticks halted; commit cap 4096, peak cap 8192, both start full.
    localparam vec_t VECS [9] = '{
        '{1'b1, 1'b0, 1'b0, 16'd1000, 1'b1, 18'd3096, 18'd7192},
        '{1'b1, 1'b0, 1'b0, 16'd3000, 1'b1, 18'd96,   18'd4192},
        '{1'b1, 1'b0, 1'b0, 16'd97,   1'b0, 18'd96,   18'd4192},
        '{1'b1, 1'b0, 1'b0, 16'd96,   1'b1, 18'd0,    18'd4096},
        '{1'b1, 1'b0, 1'b0, 16'd0,    1'b1, 18'd0,    18'd4096},
        '{1'b1, 1'b1, 1'b0, 16'd1,    1'b0, 18'd0,    18'd4096},
        '{1'b0, 1'b0, 1'b0, 16'd2000, 1'b1, 18'd0,    18'd2096},
        '{1'b0, 1'b0, 1'b1, 16'd5000, 1'b1, 18'd0,    18'd2095},
        '{1'b1, 1'b0, 1'b0, 16'd1,    1'b0, 18'd0,    18'd2095}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fast_tick = '0; slow_ratio = '0;
        c_en = 1'b1; c_pkt = 1'b0; c_slow = 1'b0; c_rate = '0; c_shift = 5'd12;
        p_en = 1'b1; p_pkt = 1'b0; p_slow = 1'b0; p_rate = '0; p_shift = 5'd13;
        req_valid = 1'b0; req_len = '0;
        cycles(3);
        rst_n = 1'b1;
        check("R1 commit level after reset", 32'(c_level), 32'd4096);
        check("R1 peak level after reset", 32'(p_level), 32'd8192);

        // Vector table: R7 R8 R9 R11
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            c_en = VECS[i].en_c; c_pkt = VECS[i].pk_c; p_pkt = VECS[i].pk_p;
            req_len = VECS[i].len; req_valid = 1'b1;
            #1 check($sformatf("R7/R11 permit vec %0d", i), 32'(permit), 32'(VECS[i].perm));
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R8/R9 commit level vec %0d", i), 32'(c_level), 32'(VECS[i].lc));
            check($sformatf("R8/R9 peak level vec %0d", i), 32'(p_level), 32'(VECS[i].lp));
        end
        c_en = 1'b1; c_pkt = 1'b0; p_pkt = 1'b0;

        // R3: zero fast tick halts refill
        c_rate = 24'd5 << 6;
        cycles(30);
        check("R3 halted refill", 32'(c_level), 32'd0);
        // R3: period of 10 cycles
        fast_tick = 16'd10;
        cycles(9);
        check("R3 before first tick", 32'(c_level), 32'd0);
        cycles(1);
        check("R3 first tick", 32'(c_level), 32'd5);
        cycles(10);
        check("R3 second tick", 32'(c_level), 32'd10);
        // R5: 1.5 tokens per tick
        c_rate = (24'd1 << 6) | 24'd32;
        cycles(10);
        check("R5 fraction first tick", 32'(c_level), 32'd11);
        cycles(30);
        check("R5 fraction four ticks", 32'(c_level), 32'd16);
        // R6: saturation
        c_rate = 24'd5000 << 6;
        cycles(10);
        check("R6 saturate", 32'(c_level), 32'd4096);
        cycles(10);
        check("R6 stay at cap", 32'(c_level), 32'd4096);
        // R10: debit and refill in the same cycle
        c_rate = 24'd100 << 6;
        cycles(9);
        req_len = 16'd500; req_valid = 1'b1;
        #1 check("R10 permit in tick cycle", 32'(permit), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 commit debit+refill", 32'(c_level), 32'd3696);
        check("R10 peak debit", 32'(p_level), 32'd1595);

        // R2: shift clamping
        fast_tick = '0; rst_n = 1'b0; c_shift = 5'd3; p_shift = 5'd25;
        cycles(2);
        check("R2 low clamp", 32'(c_level), 32'd4096);
        check("R2 high clamp", 32'(p_level), 32'd131072);

        // R4: slow tick, period 4 x 3
        c_shift = 5'd12; p_en = 1'b0; fast_tick = 16'd4; slow_ratio = 14'd3;
        c_slow = 1'b1; c_rate = 24'd7 << 6;
        cycles(2);
        rst_n = 1'b1;
        req_len = 16'd4096; req_valid = 1'b1;
        #1 check("R9 disabled peak does not block", 32'(permit), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 drained", 32'(c_level), 32'd0);
        check("R9 disabled peak not debited", 32'(p_level), 32'd131072);
        cycles(10);
        check("R4 no refill on fast ticks", 32'(c_level), 32'd0);
        cycles(1);
        check("R4 first slow tick", 32'(c_level), 32'd7);
        cycles(12);
        check("R4 second slow tick", 32'(c_level), 32'd14);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule